// File: doc/BRIEF.md
# Register-Mapped Pin Controller with Set/Clear Access

This block controls a bank of general-purpose pins through a simple single-cycle 32-bit bus. Each bus write is one cycle. Reads are combinational from the address. It drives three regular bidirectional ports of 8, 24 and 13 pins. It also drives one irregular port that packs six bidirectional pins, 24 dedicated outputs and 22 dedicated inputs into shared registers.

Pin levels, pin directions and a 13-bit mux-select vector are never written directly. Software writes a one to a set register or to a clear register for each bit it wants to change, so a read-modify-write is never needed. Separate state registers read the stored values back.

Raw pad inputs pass through two flip-flops before software can see them. The irregular port places its pins at scattered bit positions, and its bidirectional directions live in the 13-pin port's direction registers.

Top module: `pin_ctl_top`

## Requirements
- R1: On a regular port, a one written to a bit of the output-set register (8-pin port 0x044, 24-pin 0x064, 13-pin 0x020) drives that pin high. A one written to the output-clear register (0x048, 0x068, 0x024) drives it low. Zero bits leave the pin unchanged. The output-state register (0x04C, 0x06C) reads the levels back on bits 0 up, and bits above the port width read zero.
- R2: A one written to a direction-set register (0x050, 0x070, 0x010 bits 0-12) makes that pin an output (oe=1). A one written to the direction-clear register (0x054, 0x074, 0x014) makes it an input. The direction-state registers 0x058, 0x078 and 0x018 read the directions back.
- R3: The input-state registers (0x040, 0x06C-free 0x060, 0x01C) show each raw pad input after a two-flop synchronizer. A pad change becomes readable after the second rising edge, not after the first.
- R4: Bits 25-30 of 0x004 (set) and 0x008 (clear) drive irregular bidirectional pins 0-5 high and low.
- R5: Bits 25-30 of 0x010 and 0x014 set and clear the directions of irregular bidirectional pins 0-5. 0x018 reads them back on bits 25-30. Clearing those bits leaves the 13-pin port's directions alone.
- R6: Register 0x000 reports irregular bidirectional inputs 0-4 at bits 10-14 and input 5 at bit 24.
- R7: Bits 0-23 of 0x004 and 0x008 set and clear the 24 dedicated outputs, and 0x00C reads their levels back on bits 0-23.
- R8: Register 0x000 reports dedicated inputs 0-9 at bits 0-9, inputs 10-18 at bits 15-23 and inputs 19-21 at bits 25-27. Bits 28-31 read zero.
- R9: Dedicated pins have no direction. Ones written to bits 13-24 or bit 31 of 0x010, and to bits 24 or 31 of 0x004, change no output. Those bits of 0x018 read zero.
- R10: 0x028 sets and 0x02C clears bits of the 13-bit mux-select output, and 0x030 reads it back.
- R11: After reset, every output level, output enable and mux bit is zero.
- R12: Writes to state or input registers change nothing. Reads of set or clear registers and of unmapped offsets return zero.
- R13: A level or direction write shows on the outputs right after the rising edge that takes it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pa_in | input | A_W | 8-pin port raw pad inputs |
| pa_out | output | A_W | 8-pin port output levels |
| pa_oe | output | A_W | 8-pin port output enables |
| pb_in | input | B_W | 24-pin port raw pad inputs |
| pb_out | output | B_W | 24-pin port output levels |
| pb_oe | output | B_W | 24-pin port output enables |
| pc_in | input | C_W | 13-pin port raw pad inputs |
| pc_out | output | C_W | 13-pin port output levels |
| pc_oe | output | C_W | 13-pin port output enables |
| mux_sel | output | C_W | Mux-select vector |
| xb_in | input | 6 | Irregular bidirectional raw inputs |
| xb_out | output | 6 | Irregular bidirectional output levels |
| xb_oe | output | 6 | Irregular bidirectional output enables |
| xd_in | input | 22 | Dedicated raw inputs |
| xd_out | output | 24 | Dedicated output levels |

## Verification
The bench walks a single one across every pin of every port and computes the scattered bit placement of register 0x000 on its own. A design with a wrong shift would light the wrong bit, and a design that swapped the bit-24 special case would report a dedicated input where bidirectional pin 5 belongs. It writes all ones into the shared direction register. A design that decoded bits 13-24 or 31 there would show them in the readback or disturb the dedicated outputs. It also clears only bits 25-30, which catches a decoder that lets the irregular port's bits spill into the 13-pin port. Finally, it samples input registers one edge after a pad change, so a design with one synchronizer flop instead of two shows the new value too early.

// File: rtl/pin_ctl_pkg.sv
`timescale 1ns/1ps
// Shared register offsets and irregular-port bit placement for pin_ctl_top.
// Assumes an 8-bit byte address; all registers are 32 bits wide.
package pin_ctl_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int XB_W    = 6;    // irregular bidirectional pins
    localparam int XO_W    = 24;   // dedicated outputs
    localparam int XI_W    = 22;   // dedicated inputs
    localparam int XB_LSB  = 25;   // bidir bits in set/clear/direction words

    typedef logic [ADDR_W-1:0] addr_t;

    // irregular port
    localparam addr_t X_IN     = 8'h00;
    localparam addr_t X_OSET   = 8'h04;
    localparam addr_t X_OCLR   = 8'h08;
    localparam addr_t X_OSTATE = 8'h0C;
    // 13-pin port (its direction words also hold irregular bidir directions)
    localparam addr_t C_DSET   = 8'h10;
    localparam addr_t C_DCLR   = 8'h14;
    localparam addr_t C_DSTATE = 8'h18;
    localparam addr_t C_IN     = 8'h1C;
    localparam addr_t C_OSET   = 8'h20;
    localparam addr_t C_OCLR   = 8'h24;
    localparam addr_t M_SET    = 8'h28;
    localparam addr_t M_CLR    = 8'h2C;
    localparam addr_t M_STATE  = 8'h30;
    // 8-pin port
    localparam addr_t A_IN     = 8'h40;
    localparam addr_t A_OSET   = 8'h44;
    localparam addr_t A_OCLR   = 8'h48;
    localparam addr_t A_OSTATE = 8'h4C;
    localparam addr_t A_DSET   = 8'h50;
    localparam addr_t A_DCLR   = 8'h54;
    localparam addr_t A_DSTATE = 8'h58;
    // 24-pin port
    localparam addr_t B_IN     = 8'h60;
    localparam addr_t B_OSET   = 8'h64;
    localparam addr_t B_OCLR   = 8'h68;
    localparam addr_t B_OSTATE = 8'h6C;
    localparam addr_t B_DSET   = 8'h70;
    localparam addr_t B_DCLR   = 8'h74;
    localparam addr_t B_DSTATE = 8'h78;

    // Bit of the irregular input word that carries bidirectional input j.
    function automatic int bid_in_pos(input int j);
        return (j < 5) ? 10 + j : 24;
    endfunction

    // Bit of the irregular input word that carries dedicated input i.
    function automatic int ded_in_pos(input int i);
        return (i < 10) ? i : ((i < 19) ? i + 5 : i + 6);
    endfunction
endpackage

// File: rtl/pin_ctl_wr1.sv
`timescale 1ns/1ps
// Write-one-to-set / write-one-to-clear state register.
// Assumes set_en and clr_en are never high in the same cycle (distinct
// addresses); set wins if they are. Resets to zero.
module pin_ctl_wr1 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);
    // Apply set or clear mask to the stored bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (set_en) q <= q | bits;
        else if (clr_en) q <= q & ~bits;
    end

    // R1/R2/R10: every bit written with one on set ends up high
    assert_set_sticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((q & $past(bits)) == $past(bits)));
    // R1/R2/R10: every bit written with one on clear ends up low
    assert_clr_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((q & $past(bits)) == '0));
    // R13: without a strobe the state holds
    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(q));
endmodule

// File: rtl/pin_ctl_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a vector of raw pad inputs.
// Assumes each bit is sampled independently (no bus coherency needed).
module pin_ctl_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;
    logic [1:0]   age;

    // Two capture stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

    // Cycles since reset, saturating at two (used only by the check).
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    // R3: output equals the input two edges earlier
    assert_two_flop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/pin_ctl_xmap.sv
`timescale 1ns/1ps
// Packs synchronized irregular-port inputs into their scattered bit
// positions of the input-state word. Unused positions read zero.
module pin_ctl_xmap
    import pin_ctl_pkg::*;
(
    input  logic [XB_W-1:0]   bid_s,
    input  logic [XI_W-1:0]   ded_s,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] bid_part;
    logic [DATA_W-1:0] ded_part;

    for (genvar j = 0; j < XB_W; j++) begin : g_bid
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            if (b == bid_in_pos(j)) begin : g_hit
                assign bid_part[b] = bid_s[j];
            end
        end
    end
    for (genvar i = 0; i < XI_W; i++) begin : g_ded
        assign ded_part[ded_in_pos(i)] = ded_s[i];
    end
    // Positions owned by neither group.
    for (genvar b = 0; b < DATA_W; b++) begin : g_fill
        if (!((b >= 10 && b <= 14) || b == 24)) begin : g_nb
            assign bid_part[b] = 1'b0;
        end
        if (!(b <= 9 || (b >= 15 && b <= 23) || (b >= 25 && b <= 27))) begin : g_nd
            assign ded_part[b] = 1'b0;
        end
    end

    // Merge the two disjoint groups into one word.
    assign word = bid_part | ded_part;
endmodule

// File: rtl/pin_ctl_top.sv
`timescale 1ns/1ps
// Register-mapped pin controller: three regular ports, one irregular port
// with scattered bit placement, and a mux-select vector. All state changes
// through write-one-to-set / write-one-to-clear registers. Assumes a
// single-cycle bus: one write per bus_wen cycle, combinational read data.
module pin_ctl_top
    import pin_ctl_pkg::*;
#(
    parameter int A_W = 8,
    parameter int B_W = 24,
    parameter int C_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [A_W-1:0]    pa_in,
    output logic [A_W-1:0]    pa_out,
    output logic [A_W-1:0]    pa_oe,
    input  logic [B_W-1:0]    pb_in,
    output logic [B_W-1:0]    pb_out,
    output logic [B_W-1:0]    pb_oe,
    input  logic [C_W-1:0]    pc_in,
    output logic [C_W-1:0]    pc_out,
    output logic [C_W-1:0]    pc_oe,
    output logic [C_W-1:0]    mux_sel,
    input  logic [XB_W-1:0]   xb_in,
    output logic [XB_W-1:0]   xb_out,
    output logic [XB_W-1:0]   xb_oe,
    input  logic [XI_W-1:0]   xd_in,
    output logic [XO_W-1:0]   xd_out
);
    localparam int XB_MSB = XB_LSB + XB_W - 1;

    logic [A_W-1:0]    pa_s;
    logic [B_W-1:0]    pb_s;
    logic [C_W-1:0]    pc_s;
    logic [XB_W-1:0]   xb_s;
    logic [XI_W-1:0]   xd_s;
    logic [DATA_W-1:0] x_word;
    logic              unused_wdata;

    // Write strobe for one offset.
    function automatic logic hit(input addr_t a);
        return bus_wen && (bus_addr == a);
    endfunction

    assign unused_wdata = &{1'b0, bus_wdata[31], bus_wdata[24]};

    // Input synchronizers.
    pin_ctl_sync2 #(.W(A_W))  u_sa (.clk, .rst_n, .d(pa_in), .q(pa_s));
    pin_ctl_sync2 #(.W(B_W))  u_sb (.clk, .rst_n, .d(pb_in), .q(pb_s));
    pin_ctl_sync2 #(.W(C_W))  u_sc (.clk, .rst_n, .d(pc_in), .q(pc_s));
    pin_ctl_sync2 #(.W(XB_W)) u_sx (.clk, .rst_n, .d(xb_in), .q(xb_s));
    pin_ctl_sync2 #(.W(XI_W)) u_sd (.clk, .rst_n, .d(xd_in), .q(xd_s));

    // Regular-port levels and directions.
    pin_ctl_wr1 #(.W(A_W)) u_ao (.clk, .rst_n, .set_en(hit(A_OSET)), .clr_en(hit(A_OCLR)),
                                 .bits(bus_wdata[A_W-1:0]), .q(pa_out));
    pin_ctl_wr1 #(.W(A_W)) u_ad (.clk, .rst_n, .set_en(hit(A_DSET)), .clr_en(hit(A_DCLR)),
                                 .bits(bus_wdata[A_W-1:0]), .q(pa_oe));
    pin_ctl_wr1 #(.W(B_W)) u_bo (.clk, .rst_n, .set_en(hit(B_OSET)), .clr_en(hit(B_OCLR)),
                                 .bits(bus_wdata[B_W-1:0]), .q(pb_out));
    pin_ctl_wr1 #(.W(B_W)) u_bd (.clk, .rst_n, .set_en(hit(B_DSET)), .clr_en(hit(B_DCLR)),
                                 .bits(bus_wdata[B_W-1:0]), .q(pb_oe));
    pin_ctl_wr1 #(.W(C_W)) u_co (.clk, .rst_n, .set_en(hit(C_OSET)), .clr_en(hit(C_OCLR)),
                                 .bits(bus_wdata[C_W-1:0]), .q(pc_out));
    pin_ctl_wr1 #(.W(C_W)) u_cd (.clk, .rst_n, .set_en(hit(C_DSET)), .clr_en(hit(C_DCLR)),
                                 .bits(bus_wdata[C_W-1:0]), .q(pc_oe));
    pin_ctl_wr1 #(.W(C_W)) u_mx (.clk, .rst_n, .set_en(hit(M_SET)), .clr_en(hit(M_CLR)),
                                 .bits(bus_wdata[C_W-1:0]), .q(mux_sel));

    // Irregular port: shared set/clear words, directions in the 13-pin words.
    pin_ctl_wr1 #(.W(XB_W)) u_xo (.clk, .rst_n, .set_en(hit(X_OSET)), .clr_en(hit(X_OCLR)),
                                  .bits(bus_wdata[XB_MSB:XB_LSB]), .q(xb_out));
    pin_ctl_wr1 #(.W(XB_W)) u_xd (.clk, .rst_n, .set_en(hit(C_DSET)), .clr_en(hit(C_DCLR)),
                                  .bits(bus_wdata[XB_MSB:XB_LSB]), .q(xb_oe));
    pin_ctl_wr1 #(.W(XO_W)) u_do (.clk, .rst_n, .set_en(hit(X_OSET)), .clr_en(hit(X_OCLR)),
                                  .bits(bus_wdata[XO_W-1:0]), .q(xd_out));

    pin_ctl_xmap u_xmap (.bid_s(xb_s), .ded_s(xd_s), .word(x_word));

    // Read mux: state and input registers only, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            X_IN:     bus_rdata = x_word;
            X_OSTATE: bus_rdata = DATA_W'(xd_out);
            C_DSTATE: bus_rdata = DATA_W'(pc_oe) | (DATA_W'(xb_oe) << XB_LSB);
            C_IN:     bus_rdata = DATA_W'(pc_s);
            M_STATE:  bus_rdata = DATA_W'(mux_sel);
            A_IN:     bus_rdata = DATA_W'(pa_s);
            A_OSTATE: bus_rdata = DATA_W'(pa_out);
            A_DSTATE: bus_rdata = DATA_W'(pa_oe);
            B_IN:     bus_rdata = DATA_W'(pb_s);
            B_OSTATE: bus_rdata = DATA_W'(pb_out);
            B_DSTATE: bus_rdata = DATA_W'(pb_oe);
            default:  bus_rdata = '0;
        endcase
    end

    // R9: dedicated outputs move only on the irregular set/clear offsets
    assert_ded_only_xwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wen && (bus_addr == X_OSET || bus_addr == X_OCLR)) |=> $stable(xd_out));
    // R5: bidir directions move only on the shared direction offsets
    assert_xoe_only_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wen && (bus_addr == C_DSET || bus_addr == C_DCLR)) |=> $stable(xb_oe));
    // R12: set and clear offsets read zero
    assert_setclr_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_OSET || bus_addr == B_OCLR || bus_addr == X_OSET || bus_addr == M_CLR)
        |-> (bus_rdata == '0));
endmodule

// File: tb/test_pin_ctl_top.sv
`timescale 1ns/1ps
module test_pin_ctl_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wen;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [7:0]  pa_in, pa_out, pa_oe;
    logic [23:0] pb_in, pb_out, pb_oe;
    logic [12:0] pc_in, pc_out, pc_oe, mux_sel;
    logic [5:0]  xb_in, xb_out, xb_oe;
    logic [21:0] xd_in;
    logic [23:0] xd_out;
    int checks = 0, errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    pin_ctl_top i_pin_ctl_top (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wen = 1'b0; bus_addr = 8'hFC; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    // Port k: 0 = 8-pin, 1 = 24-pin, 2 = 13-pin.
    function automatic logic [31:0] port_out(input int k);
        return k == 0 ? 32'(pa_out) : (k == 1 ? 32'(pb_out) : 32'(pc_out));
    endfunction
    function automatic logic [31:0] port_oe(input int k);
        return k == 0 ? 32'(pa_oe) : (k == 1 ? 32'(pb_oe) : 32'(pc_oe));
    endfunction

    task automatic drive_pad(input int k, input logic [31:0] v);
        if (k == 0) pa_in = v[7:0];
        else if (k == 1) pb_in = v[23:0];
        else pc_in = v[12:0];
    endtask

    task automatic sweep_port(input int k, input int w, input logic [7:0] base_o,
                              input logic [7:0] oset, input logic [7:0] oclr,
                              input logic [7:0] dset, input logic [7:0] dclr,
                              input logic [7:0] dstate, input logic [7:0] inreg);
        logic [31:0] exp, r, mask;
        mask = (32'd1 << w) - 1;
        exp = 0;
        for (int i = 0; i < w; i++) begin
            wr(oset, 32'd1 << i); exp |= 32'd1 << i;
            chk("R1 walk set", port_out(k), exp);
        end
        if (base_o != 8'hFF) begin rd(base_o, r); chk("R1 state readback", r, mask); end
        for (int i = 0; i < w; i += 2) begin
            wr(oclr, 32'd1 << i); exp &= ~(32'd1 << i);
            chk("R1 walk clear", port_out(k), exp);
        end
        wr(oset, 32'd0); chk("R1 zero set no change", port_out(k), exp);
        wr(oclr, 32'd0); chk("R1 zero clear no change", port_out(k), exp);
        wr(oset, 32'hFFFF_FFFF); chk("R1 wide set", port_out(k), mask);
        if (base_o != 8'hFF) begin rd(base_o, r); chk("R1 upper bits zero", r, mask); end
        wr(oclr, 32'hFFFF_FFFF); chk("R1 wide clear", port_out(k), 0);
        exp = 0;
        for (int i = 0; i < w; i++) begin
            wr(dset, 32'd1 << i); exp |= 32'd1 << i;
            chk("R2 dir walk set", port_oe(k), exp);
        end
        rd(dstate, r); chk("R2 dir readback", r & mask, mask);
        for (int i = 1; i < w; i += 2) begin
            wr(dclr, 32'd1 << i); exp &= ~(32'd1 << i);
            chk("R2 dir walk clear", port_oe(k), exp);
        end
        rd(dstate, r); chk("R2 dir readback partial", r & mask, exp);
        wr(dclr, mask); chk("R2 all inputs", port_oe(k), 0);
        // R3: one edge later still old, two edges later new
        for (int p = 0; p < 3; p++) begin
            logic [31:0] pat;
            pat = (p == 0 ? 32'hA5A5_A5A5 : (p == 1 ? 32'h5A5A_5A5A : 32'hFFFF_FFFF)) & mask;
            @(negedge clk); bus_addr = inreg; drive_pad(k, pat);
            @(posedge clk); #1 chk("R3 one edge still old", bus_rdata,
                                  p == 0 ? 32'd0 : ((p == 1 ? 32'hA5A5_A5A5 : 32'h5A5A_5A5A) & mask));
            @(posedge clk); #1 chk("R3 two edges new", bus_rdata, pat);
        end
        drive_pad(k, 0); repeat (3) @(posedge clk);
    endtask

    logic [31:0] r;
    logic [23:0] dexp;

    initial begin
        rst_n = 1'b0; bus_wen = 1'b0; bus_addr = 8'hFC; bus_wdata = '0;
        pa_in = '0; pb_in = '0; pc_in = '0; xb_in = '0; xd_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R11: reset state
        chk("R11 outputs", {pa_out, pa_oe, pc_out, xb_out, xb_oe}, 0);
        chk("R11 wide outputs", {pb_out | pb_oe, 8'h0}, 0);
        chk("R11 mux and ded", {mux_sel, pc_oe, 6'h0} | 32'(xd_out), 0);
        rd(8'h4C, r); chk("R11 state 0x04C", r, 0);
        rd(8'h78, r); chk("R11 state 0x078", r, 0);
        rd(8'h18, r); chk("R11 state 0x018", r, 0);
        rd(8'h30, r); chk("R11 state 0x030", r, 0);
        rd(8'h0C, r); chk("R11 state 0x00C", r, 0);

        // R13: not visible before the edge, visible right after
        @(negedge clk); bus_wen = 1'b1; bus_addr = 8'h44; bus_wdata = 32'h81;
        #1 chk("R13 before edge", 32'(pa_out), 0);
        @(posedge clk); #1 chk("R13 after edge", 32'(pa_out), 32'h81);
        @(negedge clk); bus_wen = 1'b0; bus_addr = 8'hFC;
        wr(8'h48, 32'hFF);

        sweep_port(0, 8,  8'h4C, 8'h44, 8'h48, 8'h50, 8'h54, 8'h58, 8'h40);
        sweep_port(1, 24, 8'h6C, 8'h64, 8'h68, 8'h70, 8'h74, 8'h78, 8'h60);
        sweep_port(2, 13, 8'hFF, 8'h20, 8'h24, 8'h10, 8'h14, 8'h18, 8'h1C);

        // R4: bidirectional levels on bits 25-30
        wr(8'h04, 32'h7E00_0000); chk("R4 bidir set", 32'(xb_out), 32'h3F);
        chk("R4 ded untouched", 32'(xd_out), 0);
        wr(8'h08, 32'h0A00_0000); chk("R4 bidir clear", 32'(xb_out), 32'h3A);
        wr(8'h08, 32'h7E00_0000); chk("R4 bidir all low", 32'(xb_out), 0);

        // R7: dedicated outputs walk
        dexp = 0;
        for (int i = 0; i < 24; i++) begin
            wr(8'h04, 32'd1 << i); dexp |= 24'd1 << i;
            chk("R7 ded set", 32'(xd_out), 32'(dexp));
        end
        rd(8'h0C, r); chk("R7 ded readback", r, 32'h00FF_FFFF);
        wr(8'h08, 32'h0055_5555); chk("R7 ded clear", 32'(xd_out), 32'h00AA_AAAA);
        rd(8'h0C, r); chk("R7 ded readback partial", r, 32'h00AA_AAAA);

        // R9: bits 24 and 31 of the irregular set word do nothing
        wr(8'h04, 32'h8100_0000);
        chk("R9 ded after bit24/31", 32'(xd_out), 32'h00AA_AAAA);
        chk("R9 bidir after bit24/31", 32'(xb_out), 0);
        // R5/R9: shared direction word
        wr(8'h10, 32'hFFFF_FFFF);
        chk("R5 bidir dir set", 32'(xb_oe), 32'h3F);
        rd(8'h18, r); chk("R9 dir readback holes zero", r, 32'h7E00_1FFF);
        chk("R9 ded unaffected by dir", 32'(xd_out), 32'h00AA_AAAA);
        wr(8'h14, 32'h7E00_0000);
        chk("R5 bidir dir clear", 32'(xb_oe), 0);
        chk("R5 13-pin dir kept", 32'(pc_oe), 32'h1FFF);
        wr(8'h14, 32'h0000_1FFF);
        chk("R5 13-pin dir cleared", 32'(pc_oe), 0);

        // R10: mux select
        for (int i = 0; i < 13; i++) begin
            wr(8'h28, 32'd1 << i);
            chk("R10 mux set", 32'(mux_sel), (32'd2 << i) - 1);
        end
        wr(8'h2C, 32'h0F0F); chk("R10 mux clear", 32'(mux_sel), 32'h10F0);
        rd(8'h30, r); chk("R10 mux readback", r, 32'h10F0);

        // R12: writes to state/input registers ignored, set/clear read zero
        wr(8'h4C, 32'hFFFF_FFFF); chk("R12 write state ignored", 32'(pa_out), 0);
        wr(8'h58, 32'hFFFF_FFFF); chk("R12 write dir state ignored", 32'(pa_oe), 0);
        wr(8'h30, 32'hFFFF_FFFF); chk("R12 write mux state ignored", 32'(mux_sel), 32'h10F0);
        wr(8'h0C, 32'hFFFF_FFFF); chk("R12 write 0x00C ignored", 32'(xd_out), 32'h00AA_AAAA);
        wr(8'h00, 32'hFFFF_FFFF); chk("R12 write 0x000 ignored", 32'(xd_out), 32'h00AA_AAAA);
        rd(8'h04, r); chk("R12 set reads zero", r, 0);
        rd(8'h2C, r); chk("R12 clear reads zero", r, 0);
        rd(8'h34, r); chk("R12 unmapped 0x034", r, 0);
        rd(8'hFC, r); chk("R12 unmapped 0x0FC", r, 0);

        // R6: bidirectional inputs
        for (int j = 0; j < 6; j++) begin
            @(negedge clk); xb_in = 6'd1 << j; xd_in = '0;
            repeat (3) @(posedge clk);
            rd(8'h00, r);
            chk("R6 bidir input bit", r, j < 5 ? (32'd1 << (10 + j)) : 32'h0100_0000);
        end
        // R8: dedicated inputs
        for (int i = 0; i < 22; i++) begin
            logic [21:0] v;
            v = 22'd1 << i;
            @(negedge clk); xb_in = '0; xd_in = v;
            repeat (3) @(posedge clk);
            rd(8'h00, r);
            chk("R8 ded input bit", r, {4'b0, v[21:19], 1'b0, v[18:10], 5'b0, v[9:0]});
        end
        @(negedge clk); xb_in = 6'h3F; xd_in = 22'h3F_FFFF;
        repeat (3) @(posedge clk);
        rd(8'h00, r); chk("R6 R8 all ones", r, 32'h0FFF_FFFF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule